// File: doc/BRIEF.md
# Watchdog Timer with Single or Paired Clear

This block is a watchdog counter that advances on a clock-enable pulse. The pulse comes either from the instruction-rate tick or from a dedicated slow oscillator tick. After 2^CNT_W ticks with no valid clear, the counter overflows. The overflow raises a one-cycle reset request, and the kind of request depends on whether the core is halted. If the core is running, the request is a full chip reset. If the core is halted, the request is a warm reset that restarts only the program counter and the stack pointer. Both cases also raise a sticky timeout flag.

Software keeps the watchdog alive with clear strobes, and an option selects how many it takes:
- In single mode, one clear strobe is enough.
- In paired mode, two distinct half-clear strobes must both arrive before the counter clears. They may come in either order. Each received half is held in a sticky bit until the counter clears.

Halt entry also clears the counter. While halted, a watchdog on the instruction tick stops counting. A watchdog on the oscillator tick keeps counting only if the run-in-halt option is set. When the enable option is low, the watchdog ignores all of its commands and never requests a reset. The oscillators and the instruction decoder are outside the block, so every input arrives as a one-cycle strobe.

Top module: `wdog_top`

## Requirements
- R1: With wdt_en=1, 2^CNT_W ticks after the last clear cause overflow. full_rst_req is high for exactly one cycle, in the cycle after the clock edge that took the final tick. The counter then restarts from zero.
- R2: While wdt_en=0, the counter holds at zero. The clear and halt strobes leave to_flag unchanged, and neither request ever goes high.
- R3: When pair_mode=0, a cmd_clr strobe clears the counter. cmd_clr1 and cmd_clr2 have no effect in this mode.
- R4: When pair_mode=1, the counter clears once both cmd_clr1 and cmd_clr2 have been seen, in either order and in the same or separate cycles. cmd_clr is ignored in this mode, and a single half on its own does not stop the timeout.
- R5: Any clear of the counter discards pending halves, whether the clear comes from a completed pair or from halt entry. A half that arrives later must then be matched by a fresh partner.
- R6: cmd_halt clears the counter and puts the block into the halted state. With src_osc=0 (instruction tick), no counting happens while halted.
- R7: With src_osc=1 (oscillator tick), the counter counts tick_osc and ignores tick_inst. While halted it counts only if run_in_halt=1.
- R8: An overflow while halted produces a one-cycle warm_rst_req, never a full_rst_req, and the block leaves the halted state. full_rst_req and warm_rst_req are never high together.
- R9: to_flag is set by any overflow. It is cleared by a completed clear, by halt entry with wdt_en=1, and by rst.
- R10: A wake strobe takes the block out of the halted state, and counting on the instruction tick resumes.
- R11: While rst is high and in the cycle after it, full_rst_req, warm_rst_req and to_flag are all 0. rst also clears the counter, the pending halves and the halted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high external reset |
| tick_inst | input | 1 | Instruction-rate tick enable |
| tick_osc | input | 1 | Dedicated oscillator tick enable |
| src_osc | input | 1 | Tick source select: 0 instruction, 1 oscillator |
| run_in_halt | input | 1 | Oscillator source keeps counting while halted |
| wdt_en | input | 1 | Watchdog enable option |
| pair_mode | input | 1 | 0 single clear, 1 paired clear |
| cmd_clr | input | 1 | Single clear strobe |
| cmd_clr1 | input | 1 | First half-clear strobe |
| cmd_clr2 | input | 1 | Second half-clear strobe |
| cmd_halt | input | 1 | Halt entry strobe |
| wake | input | 1 | Leave halt (interrupt or pin wake-up) |
| full_rst_req | output | 1 | One-cycle full chip reset request |
| warm_rst_req | output | 1 | One-cycle PC/SP-only reset request |
| to_flag | output | 1 | Sticky timeout status |

## Verification
The properties assume the following about the inputs:
- Every command is a single-cycle strobe.
- The option inputs (wdt_en, pair_mode, src_osc, run_in_halt) change only while rst is held.
- CNT_W is at least 2, so two overflows can never fall in consecutive cycles.

The stimulus stays within these assumptions. It sets the options before raising rst and keeps them steady through each scenario. Commands are issued one cycle at a time, in cycles with no tick, so the effect of each clear can be told apart from counting.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    SRC_INSTR = 1'b0,
    SRC_OSC   = 1'b1
  } wdt_src_e;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
  import wdog_pkg::*;
(
  input  logic     tick_inst,
  input  logic     tick_osc,
  input  wdt_src_e src,
  input  logic     run_in_halt,
  input  logic     halted,
  output logic     tick
);
  always_comb begin
    unique case (src)
      SRC_INSTR: tick = tick_inst & ~halted;
      SRC_OSC:   tick = tick_osc & (~halted | run_in_halt);
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdog_clr_ctrl.sv
module wdog_clr_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pair_mode,
  input  logic cmd_clr,
  input  logic cmd_clr1,
  input  logic cmd_clr2,
  input  logic cmd_halt,
  output logic clr_done,
  output logic cnt_clear
);
  logic half1_q, half2_q;
  logic have1, have2, pair_done;

  assign have1     = half1_q | cmd_clr1;
  assign have2     = half2_q | cmd_clr2;
  assign pair_done = pair_mode & have1 & have2;
  assign clr_done  = en & (pair_mode ? pair_done : cmd_clr);
  assign cnt_clear = clr_done | (en & cmd_halt);

  always_ff @(posedge clk) begin
    if (rst || cnt_clear || !en || !pair_mode) begin
      half1_q <= 1'b0;
      half2_q <= 1'b0;
    end else begin
      half1_q <= have1;
      half2_q <= have2;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clear,
  input  logic tick,
  output logic ovf
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  assign ovf = en & ~clear & tick & (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || !en || clear)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_inst,
  input  logic tick_osc,
  input  logic src_osc,
  input  logic run_in_halt,
  input  logic wdt_en,
  input  logic pair_mode,
  input  logic cmd_clr,
  input  logic cmd_clr1,
  input  logic cmd_clr2,
  input  logic cmd_halt,
  input  logic wake,
  output logic full_rst_req,
  output logic warm_rst_req,
  output logic to_flag
);
  logic halted_q;
  logic tick, ovf, clr_done, cnt_clear;
  wdt_src_e src;

  assign src = wdt_src_e'(src_osc);

  wdog_tick_sel u_tick (
    .tick_inst   (tick_inst),
    .tick_osc    (tick_osc),
    .src         (src),
    .run_in_halt (run_in_halt),
    .halted      (halted_q),
    .tick        (tick)
  );

  wdog_clr_ctrl u_clr (
    .clk       (clk),
    .rst       (rst),
    .en        (wdt_en),
    .pair_mode (pair_mode),
    .cmd_clr   (cmd_clr),
    .cmd_clr1  (cmd_clr1),
    .cmd_clr2  (cmd_clr2),
    .cmd_halt  (cmd_halt),
    .clr_done  (clr_done),
    .cnt_clear (cnt_clear)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .en    (wdt_en),
    .clear (cnt_clear),
    .tick  (tick),
    .ovf   (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst)
      halted_q <= 1'b0;
    else if (cmd_halt)
      halted_q <= 1'b1;
    else if (wake || ovf)
      halted_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_rst_req <= 1'b0;
      warm_rst_req <= 1'b0;
      to_flag      <= 1'b0;
    end else begin
      full_rst_req <= ovf & ~halted_q;
      warm_rst_req <= ovf & halted_q;
      if (ovf)
        to_flag <= 1'b1;
      else if (clr_done || (wdt_en && cmd_halt))
        to_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic clk,
  input logic rst,
  input logic wdt_en,
  input logic pair_mode,
  input logic cmd_clr,
  input logic cmd_halt,
  input logic full_rst_req,
  input logic warm_rst_req,
  input logic to_flag
);
  assert_req_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(full_rst_req && warm_rst_req));

  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !wdt_en |=> (!full_rst_req && !warm_rst_req));

  assert_single_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (wdt_en && !pair_mode && cmd_clr) |=> (!full_rst_req && !warm_rst_req && !to_flag));

  assert_halt_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (wdt_en && cmd_halt) |=> (!full_rst_req && !warm_rst_req && !to_flag));

  assert_flag_on_req_R9: assert property (@(posedge clk) disable iff (rst)
    (full_rst_req || warm_rst_req) |-> to_flag);

  assert_full_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    full_rst_req |=> !full_rst_req);

  assert_warm_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    warm_rst_req |=> !warm_rst_req);
endmodule

bind wdog_top wdog_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .wdt_en       (wdt_en),
  .pair_mode    (pair_mode),
  .cmd_clr      (cmd_clr),
  .cmd_halt     (cmd_halt),
  .full_rst_req (full_rst_req),
  .warm_rst_req (warm_rst_req),
  .to_flag      (to_flag)
);

// File: tb/wdog_top_bench.sv
module wdog_top_bench;
  localparam int W = 4;
  localparam int PERIOD = 1 << W;

  logic clk = 1'b0;
  logic rst, tick_inst, tick_osc, src_osc, run_in_halt, wdt_en, pair_mode;
  logic cmd_clr, cmd_clr1, cmd_clr2, cmd_halt, wake;
  logic full_rst_req, warm_rst_req, to_flag;
  int   n_chk = 0, n_fail = 0;
  logic seen_full, seen_warm;

  always #2.5 clk = ~clk;

  wdog_top #(.CNT_W(W)) u_wdog_top (.*);

  // cmd: 0 none, 1 clr, 2 clr1, 3 clr2, 4 clr1 then clr2, 5 halt, 6 clr2 then clr1
  typedef struct packed {
    logic pair; logic osc; logic rih; logic en;
    logic [7:0] pre; logic [2:0] cmd; logic [7:0] post;
    logic ef; logic ew; logic efl;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1, 8'd10,3'd1,8'd10, 1'b0,1'b0,1'b0}, // R3 clear in time
    '{1'b0,1'b0,1'b0,1'b1, 8'd10,3'd0,8'd10, 1'b1,1'b0,1'b1}, // R1 no clear
    '{1'b1,1'b0,1'b0,1'b1, 8'd10,3'd1,8'd10, 1'b1,1'b0,1'b1}, // R4 single ignored
    '{1'b1,1'b0,1'b0,1'b1, 8'd10,3'd2,8'd10, 1'b1,1'b0,1'b1}, // R4 one half only
    '{1'b1,1'b0,1'b0,1'b1, 8'd10,3'd4,8'd10, 1'b0,1'b0,1'b0}, // R4 half1 then half2
    '{1'b1,1'b0,1'b0,1'b1, 8'd10,3'd6,8'd10, 1'b0,1'b0,1'b0}, // R4 half2 then half1
    '{1'b0,1'b0,1'b0,1'b1, 8'd10,3'd2,8'd10, 1'b1,1'b0,1'b1}, // R3 half ignored
    '{1'b0,1'b0,1'b0,1'b0, 8'd40,3'd1,8'd40, 1'b0,1'b0,1'b0}, // R2 disabled
    '{1'b0,1'b0,1'b0,1'b1, 8'd10,3'd5,8'd40, 1'b0,1'b0,1'b0}, // R6 instr stops in halt
    '{1'b0,1'b1,1'b1,1'b1, 8'd10,3'd5,8'd20, 1'b0,1'b1,1'b1}, // R8 warm in halt
    '{1'b0,1'b1,1'b0,1'b1, 8'd10,3'd5,8'd20, 1'b0,1'b0,1'b0}, // R7 osc paused in halt
    '{1'b0,1'b1,1'b0,1'b1, 8'd20,3'd0,8'd0,  1'b1,1'b0,1'b1}  // R7 osc counts when run
  };

  function automatic string vtag(int k);
    case (k)
      0, 6:          return "R3";
      1:             return "R1";
      2, 3, 4, 5:    return "R4";
      7:             return "R2";
      8:             return "R6";
      9:             return "R8";
      default:       return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    seen_full = seen_full | full_rst_req;
    seen_warm = seen_warm | warm_rst_req;
  endtask

  task automatic idle_in();
    tick_inst = 0; tick_osc = 0; cmd_clr = 0; cmd_clr1 = 0;
    cmd_clr2 = 0; cmd_halt = 0; wake = 0;
  endtask

  task automatic cfg_reset(logic p, logic o, logic r, logic e);
    idle_in();
    pair_mode = p; src_osc = o; run_in_halt = r; wdt_en = e;
    rst = 1; step(); step(); rst = 0;
    seen_full = 0; seen_warm = 0;
  endtask

  task automatic ticks(int n);
    tick_inst = 1; tick_osc = 1;
    repeat (n) step();
    tick_inst = 0; tick_osc = 0;
  endtask

  task automatic pulse(int which);
    case (which)
      1: cmd_clr = 1;
      2: cmd_clr1 = 1;
      3: cmd_clr2 = 1;
      5: cmd_halt = 1;
      default: wake = 1;
    endcase
    step();
    idle_in();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle_in();
    seen_full = 0; seen_warm = 0;
    pair_mode = 0; src_osc = 0; run_in_halt = 0; wdt_en = 1;
    rst = 1;
    step();
    // R11 outputs during reset
    check("R11 full in reset", full_rst_req, 1'b0);
    check("R11 warm in reset", warm_rst_req, 1'b0);
    check("R11 flag in reset", to_flag, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cfg_reset(VECS[i].pair, VECS[i].osc, VECS[i].rih, VECS[i].en);
      ticks(int'(VECS[i].pre));
      case (VECS[i].cmd)
        3'd1: pulse(1);
        3'd2: pulse(2);
        3'd3: pulse(3);
        3'd4: begin pulse(2); pulse(3); end
        3'd5: pulse(5);
        3'd6: begin pulse(3); pulse(2); end
        default: step();
      endcase
      ticks(int'(VECS[i].post));
      check($sformatf("%s vec%0d full seen", vtag(i), i), seen_full, VECS[i].ef);
      check($sformatf("%s vec%0d warm seen", vtag(i), i), seen_warm, VECS[i].ew);
      check($sformatf("%s vec%0d flag", vtag(i), i), to_flag, VECS[i].efl);
    end

    // R1 exact overflow cycle and pulse width; R9 flag set and cleared
    cfg_reset(0, 0, 0, 1);
    ticks(PERIOD - 1);
    check("R1 no request one tick early", full_rst_req, 1'b0);
    ticks(1);
    check("R1 request on final tick", full_rst_req, 1'b1);
    check("R9 flag set by overflow", to_flag, 1'b1);
    step();
    check("R1 request is one cycle", full_rst_req, 1'b0);
    pulse(1);
    check("R9 flag cleared by clear", to_flag, 1'b0);

    // R5 completed pair discards halves; lone later half does not clear
    cfg_reset(1, 0, 0, 1);
    pulse(2); pulse(3);
    ticks(PERIOD / 2);
    pulse(3);
    ticks(PERIOD / 2);
    check("R5 stale half not reused", full_rst_req, 1'b1);

    // R10 wake leaves halt, instruction counting resumes
    cfg_reset(0, 0, 0, 1);
    pulse(5);
    ticks(PERIOD + 4);
    check("R10 no count in halt", seen_full | seen_warm, 1'b0);
    pulse(6);
    ticks(PERIOD);
    check("R10 counts after wake", full_rst_req, 1'b1);

    // R6 halt clears counter
    cfg_reset(0, 0, 0, 1);
    ticks(10);
    pulse(5); pulse(6);
    ticks(PERIOD - 1);
    check("R6 halt cleared count", full_rst_req, 1'b0);
    ticks(1);
    check("R6 full period after halt", full_rst_req, 1'b1);

    // R8 warm reset exits halt; next overflow is full
    cfg_reset(0, 1, 1, 1);
    pulse(5);
    ticks(PERIOD);
    check("R8 warm request in halt", warm_rst_req, 1'b1);
    check("R8 no full request in halt", full_rst_req, 1'b0);
    ticks(PERIOD);
    check("R8 halt exited, full next", full_rst_req, 1'b1);

    // R7 oscillator source ignores instruction tick
    cfg_reset(0, 1, 0, 1);
    tick_inst = 1;
    repeat (PERIOD + 2) step();
    tick_inst = 0;
    check("R7 instr tick ignored", seen_full, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule